// File: doc/BRIEF.md
# External Bus Idle and Hold Arbiter

This block owns the external memory pins of a microcontroller-style bus interface. The core presents one access at a time: an intra-segment address, a segment number, a read/write flag, write data and a flag that marks the address as belonging to an on-chip area. A set of address windows decides the shape of each external cycle. Each window has an active bit, a demultiplexed-bus bit, a chip-select enable and a segment match value. A cycle is one address-latch clock followed by a fixed number of strobe clocks.

Between cycles the pins are not released. The demultiplexed address port, the segment pins and the chip selects keep the values of the last access. The shared address/data port floats, and the latch and strobe lines rest in their inactive levels. Accesses to on-chip areas never reach the pins. An external master can take the whole bus with a hold request. It is granted only between cycles, and the block then floats every output it drives. On-chip accesses from the core keep completing during the hold, and external ones stall until the bus comes back.

Top module: `ebus_idle_hold`

## Requirements
- R1: The interface is enabled only while at least one window has its active bit set. When it is disabled, `pinOe`, `addrOe` and `adOe` stay low. An external request completes at once (`reqDone` high in its first cycle, no hold pending) and starts no cycle.
- R2: An external cycle has `ale` high for exactly one clock, then `rdN` (read) or `wrN` (write) low for XFER_CYC clocks. `reqDone` is high in the last strobe clock, and read data is taken from `adIn` at the end of that clock onto `rdData`.
- R3: `adOe` is high in the `ale` clock of a multiplexed cycle, with `adOut` carrying the address. It is high in the strobe clocks of a write, with `adOut` carrying the write data. At all other times it is low, idle included.
- R4: `addrOe` is high, with `extAddr` equal to the last captured address, whenever the bus is driven and some active window has its demultiplexed bit set. This holds during multiplexed cycles too. Otherwise `addrOe` is low.
- R5: Between cycles `ale` is low, `rdN` and `wrN` are high, and `extAddr` and `extSeg` keep the values of the last external access.
- R6: The active-low `csN` lines are selected by the active window with the lowest index whose segment value equals the access segment. Only a window with its chip-select enable set can pull its line low, and the selection is held after the cycle ends. An access with no matching window leaves all lines high and runs as a multiplexed cycle.
- R7: A request with `reqInternal` high completes in the same clock (`reqDone` high) and changes no pin, even when a window covers its segment.
- R8: `holdReq` is sampled only in idle clocks and has priority there over a pending external request. A cycle in flight runs to its end, and `hlda` rises in the clock after `holdReq` is seen in idle.
- R9: While `hlda` is high, `pinOe`, `addrOe` and `adOe` are low.
- R10: After `holdReq` is seen low during the hold, `hlda` drops in the next clock while the pins still float. The pins are driven again one clock later, with the held address, segment and select values.
- R11: `reqStall` is high while an external request is waiting and not completing, as it does throughout a hold. The waiting request runs as a normal cycle once the bus is regained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Core access request, held until `reqDone` |
| reqAddr | input | ADDR_W | Intra-segment address |
| reqSeg | input | SEG_W | Segment number |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqInternal | input | 1 | Address lies in an on-chip area |
| reqWdata | input | ADDR_W | Write data |
| reqDone | output | 1 | Access completes this clock |
| reqStall | output | 1 | External access waiting |
| rdData | output | ADDR_W | Last read data |
| winActive | input | NUM_WIN | Per-window active bits |
| winDemux | input | NUM_WIN | Per-window demultiplexed-bus bits |
| winCsEn | input | NUM_WIN | Per-window chip-select enables |
| winSeg | input | NUM_WIN*SEG_W | Per-window segment values, window i at bits i*SEG_W |
| holdReq | input | 1 | External master bus request |
| hlda | output | 1 | Bus granted to external master |
| adIn | input | ADDR_W | Shared address/data port input |
| adOut | output | ADDR_W | Shared address/data port output value |
| adOe | output | 1 | Shared port drive enable |
| extAddr | output | ADDR_W | Demultiplexed address port |
| addrOe | output | 1 | Demultiplexed address port drive enable |
| extSeg | output | SEG_W | Segment address pins |
| csN | output | NUM_WIN | Chip selects, active low |
| pinOe | output | 1 | Drive enable for segment, select, latch and strobe pins |
| ale | output | 1 | Address latch enable |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |

## Verification
The bench builds the block with ADDR_W=16, SEG_W=4 and NUM_WIN=4, and raises XFER_CYC to 3. The longer strobe leaves room to raise a hold in the middle of a cycle and confirm the grant waits for its end. The four windows are chosen so that two active windows share a segment, which tests the priority. One window is inactive and one lacks its select enable. Mixing multiplexed and demultiplexed windows shows the address port staying driven during multiplexed cycles, and clearing all demultiplexed bits shows it released.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALE,
    ST_XFER,
    ST_HOLD,
    ST_REL
  } busState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // load a new external access
    logic latchRd;    // take read data from the shared port
    logic addrPhase;  // address latch clock
    logic dataPhase;  // strobe clocks
    logic floatPins;  // bus handed to another master
  } busStrobe_t;

endpackage

// File: rtl/ebus_win_decode.sv
module ebus_win_decode #(
  parameter int NUM_WIN = 4,
  parameter int SEG_W   = 4
) (
  input  logic [NUM_WIN-1:0]       winActive,
  input  logic [NUM_WIN-1:0]       winDemux,
  input  logic [NUM_WIN*SEG_W-1:0] winSeg,
  input  logic [SEG_W-1:0]         reqSeg,
  output logic [NUM_WIN-1:0]       hitOneHot,
  output logic                     hitDemux,
  output logic                     busEn,
  output logic                     anyDemux
);

  logic [NUM_WIN-1:0] match;
  logic [NUM_WIN:0]   taken;

  assign taken[0] = 1'b0;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    assign match[i]     = winActive[i] && (winSeg[i*SEG_W +: SEG_W] == reqSeg);
    assign hitOneHot[i] = match[i] && !taken[i];
    assign taken[i+1]   = taken[i] || match[i];
  end

  assign hitDemux = |(hitOneHot & winDemux);
  assign busEn    = |winActive;
  assign anyDemux = |(winActive & winDemux);

endmodule

// File: rtl/ebus_ctrl.sv
module ebus_ctrl
  import ebus_pkg::*;
#(
  parameter int XFER_CYC = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       reqInternal,
  input  logic       holdReq,
  input  logic       busEn,
  output busStrobe_t strobe,
  output logic       ale,
  output logic       rdN,
  output logic       wrN,
  output logic       hlda,
  output logic       reqDone,
  output logic       reqStall
);

  localparam int CNT_W = (XFER_CYC > 1) ? $clog2(XFER_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(XFER_CYC - 1);

  busState_t       state, stateNxt;
  logic [CNT_W-1:0] cnt;
  logic            curWrite;
  logic            startExt, xferEnd, discard;

  assign startExt = (state == ST_IDLE) && reqValid && !reqInternal && busEn && !holdReq;
  assign xferEnd  = (state == ST_XFER) && (cnt == LAST_CNT);
  assign discard  = (state == ST_IDLE) && reqValid && !reqInternal && !busEn && !holdReq;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE: begin
        if (holdReq)       stateNxt = ST_HOLD;
        else if (startExt) stateNxt = ST_ALE;
      end
      ST_ALE:  stateNxt = ST_XFER;
      ST_XFER: if (xferEnd) stateNxt = ST_IDLE;
      ST_HOLD: if (!holdReq) stateNxt = ST_REL;
      ST_REL:  stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      curWrite <= 1'b0;
    end else begin
      state <= stateNxt;
      if (startExt) curWrite <= reqWrite;
      if (state == ST_XFER) cnt <= cnt + CNT_W'(1);
      else                  cnt <= '0;
    end
  end

  always_comb begin
    strobe.capture   = startExt;
    strobe.latchRd   = xferEnd && !curWrite;
    strobe.addrPhase = (state == ST_ALE);
    strobe.dataPhase = (state == ST_XFER);
    strobe.floatPins = (state == ST_HOLD) || (state == ST_REL);
  end

  assign ale      = (state == ST_ALE);
  assign rdN      = !((state == ST_XFER) && !curWrite);
  assign wrN      = !((state == ST_XFER) && curWrite);
  assign hlda     = (state == ST_HOLD);
  assign reqDone  = (reqValid && reqInternal) || discard || xferEnd;
  assign reqStall = reqValid && !reqInternal && !reqDone;

endmodule

// File: rtl/ebus_dpath.sv
module ebus_dpath
  import ebus_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int SEG_W   = 4,
  parameter int NUM_WIN = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  busStrobe_t         strobe,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [SEG_W-1:0]   reqSeg,
  input  logic               reqWrite,
  input  logic [ADDR_W-1:0]  reqWdata,
  input  logic [NUM_WIN-1:0] hitOneHot,
  input  logic               hitDemux,
  input  logic [NUM_WIN-1:0] winCsEn,
  input  logic               busEn,
  input  logic               anyDemux,
  input  logic [ADDR_W-1:0]  adIn,
  output logic [ADDR_W-1:0]  adOut,
  output logic               adOe,
  output logic [ADDR_W-1:0]  extAddr,
  output logic               addrOe,
  output logic [SEG_W-1:0]   extSeg,
  output logic [NUM_WIN-1:0] csN,
  output logic               pinOe,
  output logic [ADDR_W-1:0]  rdData
);

  logic [ADDR_W-1:0]  lastAddr, curWdata;
  logic [SEG_W-1:0]   lastSeg;
  logic [NUM_WIN-1:0] lastHit;
  logic               curWrite, curDemux;

  always_ff @(posedge clk) begin
    if (rst) begin
      lastAddr <= '0;
      lastSeg  <= '0;
      lastHit  <= '0;
      curWdata <= '0;
      curWrite <= 1'b0;
      curDemux <= 1'b0;
      rdData   <= '0;
    end else begin
      if (strobe.capture) begin
        lastAddr <= reqAddr;
        lastSeg  <= reqSeg;
        lastHit  <= hitOneHot;
        curWdata <= reqWdata;
        curWrite <= reqWrite;
        curDemux <= hitDemux;
      end
      if (strobe.latchRd) rdData <= adIn;
    end
  end

  assign pinOe   = busEn && !strobe.floatPins;
  assign addrOe  = pinOe && anyDemux;
  assign extAddr = lastAddr;
  assign extSeg  = lastSeg;
  assign csN     = ~(lastHit & winCsEn);
  assign adOe    = busEn && ((strobe.addrPhase && !curDemux) ||
                             (strobe.dataPhase && curWrite));
  assign adOut   = strobe.addrPhase ? lastAddr : curWdata;

endmodule

// File: rtl/ebus_idle_hold.sv
module ebus_idle_hold
  import ebus_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int SEG_W    = 4,
  parameter int NUM_WIN  = 4,
  parameter int XFER_CYC = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     reqValid,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [SEG_W-1:0]         reqSeg,
  input  logic                     reqWrite,
  input  logic                     reqInternal,
  input  logic [ADDR_W-1:0]        reqWdata,
  output logic                     reqDone,
  output logic                     reqStall,
  output logic [ADDR_W-1:0]        rdData,
  input  logic [NUM_WIN-1:0]       winActive,
  input  logic [NUM_WIN-1:0]       winDemux,
  input  logic [NUM_WIN-1:0]       winCsEn,
  input  logic [NUM_WIN*SEG_W-1:0] winSeg,
  input  logic                     holdReq,
  output logic                     hlda,
  input  logic [ADDR_W-1:0]        adIn,
  output logic [ADDR_W-1:0]        adOut,
  output logic                     adOe,
  output logic [ADDR_W-1:0]        extAddr,
  output logic                     addrOe,
  output logic [SEG_W-1:0]         extSeg,
  output logic [NUM_WIN-1:0]       csN,
  output logic                     pinOe,
  output logic                     ale,
  output logic                     rdN,
  output logic                     wrN
);

  busStrobe_t         strobe;
  logic [NUM_WIN-1:0] hitOneHot;
  logic               hitDemux, busEn, anyDemux;

  ebus_win_decode #(.NUM_WIN(NUM_WIN), .SEG_W(SEG_W)) u_dec (
    .winActive(winActive), .winDemux(winDemux), .winSeg(winSeg),
    .reqSeg(reqSeg), .hitOneHot(hitOneHot), .hitDemux(hitDemux),
    .busEn(busEn), .anyDemux(anyDemux)
  );

  ebus_ctrl #(.XFER_CYC(XFER_CYC)) u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqInternal(reqInternal), .holdReq(holdReq), .busEn(busEn),
    .strobe(strobe), .ale(ale), .rdN(rdN), .wrN(wrN), .hlda(hlda),
    .reqDone(reqDone), .reqStall(reqStall)
  );

  ebus_dpath #(.ADDR_W(ADDR_W), .SEG_W(SEG_W), .NUM_WIN(NUM_WIN)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .reqAddr(reqAddr),
    .reqSeg(reqSeg), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .hitOneHot(hitOneHot), .hitDemux(hitDemux), .winCsEn(winCsEn),
    .busEn(busEn), .anyDemux(anyDemux), .adIn(adIn), .adOut(adOut),
    .adOe(adOe), .extAddr(extAddr), .addrOe(addrOe), .extSeg(extSeg),
    .csN(csN), .pinOe(pinOe), .rdData(rdData)
  );

endmodule

// File: rtl/ebus_idle_hold_chk.sv
module ebus_idle_hold_chk #(
  parameter int ADDR_W  = 16,
  parameter int SEG_W   = 4,
  parameter int NUM_WIN = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               reqValid,
  input logic               reqInternal,
  input logic               reqDone,
  input logic [NUM_WIN-1:0] winActive,
  input logic               holdReq,
  input logic               hlda,
  input logic               adOe,
  input logic               addrOe,
  input logic               pinOe,
  input logic [ADDR_W-1:0]  extAddr,
  input logic [SEG_W-1:0]   extSeg,
  input logic               ale,
  input logic               rdN,
  input logic               wrN
);

  // R1
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (winActive == '0) |-> (!pinOe && !addrOe && !adOe));

  // R2
  ale_then_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    ale |=> (!rdN || !wrN) && !ale);

  // R5
  idle_hold_value_chk: assert property (@(posedge clk) disable iff (rst)
    (!ale && rdN && wrN && $past(!ale && rdN && wrN)) |->
      ($stable(extAddr) && $stable(extSeg)));

  // R7
  internal_done_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqInternal) |-> reqDone);

  // R8
  grant_between_cycles_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hlda) |-> $past(!ale && rdN && wrN && holdReq));

  // R9
  hold_float_chk: assert property (@(posedge clk) disable iff (rst)
    hlda |-> (!pinOe && !addrOe && !adOe));

  // R10
  release_float_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(hlda) |-> (!pinOe && $past(!holdReq)));

endmodule

bind ebus_idle_hold ebus_idle_hold_chk #(
  .ADDR_W(ADDR_W), .SEG_W(SEG_W), .NUM_WIN(NUM_WIN)
) u_chk (
  .clk(clk), .rst(rst), .reqValid(reqValid), .reqInternal(reqInternal),
  .reqDone(reqDone), .winActive(winActive), .holdReq(holdReq),
  .hlda(hlda), .adOe(adOe), .addrOe(addrOe), .pinOe(pinOe),
  .extAddr(extAddr), .extSeg(extSeg), .ale(ale), .rdN(rdN), .wrN(wrN)
);

// File: tb/ebus_idle_hold_test.sv
module ebus_idle_hold_test;

  localparam int AW = 16;
  localparam int SW = 4;
  localparam int NW = 4;
  localparam int XC = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqInternal = 1'b0, holdReq = 1'b0;
  logic [AW-1:0] reqAddr = '0, reqWdata = '0, adIn = '0;
  logic [SW-1:0] reqSeg = '0;
  logic [NW-1:0] winActive = '0, winDemux = '0, winCsEn = '0;
  logic [NW*SW-1:0] winSeg = '0;
  logic reqDone, reqStall, hlda, adOe, addrOe, pinOe, ale, rdN, wrN;
  logic [AW-1:0] rdData, adOut, extAddr;
  logic [SW-1:0] extSeg;
  logic [NW-1:0] csN;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  ebus_idle_hold #(.ADDR_W(AW), .SEG_W(SW), .NUM_WIN(NW), .XFER_CYC(XC)) uut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSeg(reqSeg), .reqWrite(reqWrite), .reqInternal(reqInternal),
    .reqWdata(reqWdata), .reqDone(reqDone), .reqStall(reqStall),
    .rdData(rdData), .winActive(winActive), .winDemux(winDemux),
    .winCsEn(winCsEn), .winSeg(winSeg), .holdReq(holdReq), .hlda(hlda),
    .adIn(adIn), .adOut(adOut), .adOe(adOe), .extAddr(extAddr),
    .addrOe(addrOe), .extSeg(extSeg), .csN(csN), .pinOe(pinOe),
    .ale(ale), .rdN(rdN), .wrN(wrN)
  );

  // reference model: phase 0 idle, 1 latch, 2..XC+1 strobe, 20 hold, 21 release
  int mPh = 0;
  int mHit = -1;
  logic [AW-1:0] mAddr = '0, mWdata = '0, mRd = '0;
  logic [SW-1:0] mSeg = '0;
  logic mWrite = 1'b0, mDemux = 1'b0;

  function automatic int findWin(input logic [SW-1:0] s);
    for (int i = 0; i < NW; i++)
      if (winActive[i] && winSeg[i*SW +: SW] == s) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mPh = 0; mHit = -1; mAddr = '0; mSeg = '0; mWdata = '0;
      mWrite = 1'b0; mDemux = 1'b0; mRd = '0;
    end else begin
      case (mPh)
        0: if (holdReq) mPh = 20;
           else if (reqValid && !reqInternal && winActive != '0) begin
             mHit = findWin(reqSeg);
             mAddr = reqAddr; mSeg = reqSeg; mWdata = reqWdata;
             mWrite = reqWrite;
             mDemux = (mHit >= 0) ? winDemux[mHit] : 1'b0;
             mPh = 1;
           end
        20: if (!holdReq) mPh = 21;
        21: mPh = 0;
        default: begin
          if (mPh == XC + 1) begin
            if (!mWrite) mRd = adIn;
            mPh = 0;
          end else mPh = mPh + 1;
        end
      endcase
    end
  end

  task automatic check(input string tag, input string name,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, name, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      automatic logic en   = (winActive != '0);
      automatic logic anyD = ((winActive & winDemux) != '0);
      automatic logic xf   = (mPh >= 2) && (mPh <= XC + 1);
      automatic logic fl   = (mPh >= 20);
      automatic logic ePin = en && !fl;
      automatic logic eAdOe = en && ((mPh == 1 && !mDemux) || (xf && mWrite));
      automatic logic eDone = (reqValid && reqInternal) ||
                              (reqValid && !reqInternal && mPh == 0 && !en && !holdReq) ||
                              (mPh == XC + 1);
      automatic logic [NW-1:0] eCs = '1;
      if (mHit >= 0 && winCsEn[mHit]) eCs[mHit] = 1'b0;
      check("R1", "pinOe", 32'(pinOe), 32'(ePin));      // also R9, R10
      check("R4", "addrOe", 32'(addrOe), 32'(ePin && anyD));
      check("R3", "adOe", 32'(adOe), 32'(eAdOe));
      check("R2", "ale", 32'(ale), 32'(mPh == 1));
      check("R2", "rdN", 32'(rdN), 32'(!(xf && !mWrite)));
      check("R2", "wrN", 32'(wrN), 32'(!(xf && mWrite)));
      check("R8", "hlda", 32'(hlda), 32'(mPh == 20));
      check("R7", "reqDone", 32'(reqDone), 32'(eDone));
      check("R11", "reqStall", 32'(reqStall), 32'(reqValid && !reqInternal && !eDone));
      check("R2", "rdData", 32'(rdData), 32'(mRd));
      if (pinOe) begin
        check("R5", "extSeg", 32'(extSeg), 32'(mSeg));
        check("R6", "csN", 32'(csN), 32'(eCs));
      end
      if (addrOe) check("R4", "extAddr", 32'(extAddr), 32'(mAddr));
      if (adOe) check("R3", "adOut", 32'(adOut), 32'((mPh == 1) ? mAddr : mWdata));
    end
  end

  task automatic setReq(input logic [SW-1:0] s, input logic [AW-1:0] a,
                        input logic w, input logic in, input logic [AW-1:0] d);
    reqSeg = s; reqAddr = a; reqWrite = w; reqInternal = in; reqWdata = d;
    reqValid = 1'b1;
  endtask

  task automatic waitDone();
    forever begin
      @(negedge clk); #1;
      if (reqDone) break;
    end
    @(posedge clk); #2;
    reqValid = 1'b0;
  endtask

  task automatic doReq(input logic [SW-1:0] s, input logic [AW-1:0] a,
                       input logic w, input logic in, input logic [AW-1:0] d);
    setReq(s, a, w, in, d);
    waitDone();
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 5000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // window 0: seg 1 mux; window 1: seg 2 demux; window 2: seg 2 (shadowed);
    // window 3: seg 3 inactive; window 2 has no select enable
    winSeg  = {4'd3, 4'd2, 4'd2, 4'd1};
    winCsEn = 4'b1011;
    winDemux = 4'b0010;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    idle(2);
    // R1: disabled interface discards external requests
    doReq(4'd1, 16'h1111, 1'b0, 1'b0, 16'h0);
    idle(2);
    winActive = 4'b0111;
    idle(2);
    // R2 R3 R4 R6: multiplexed read via window 0, address port still driven
    adIn = 16'hBEEF;
    doReq(4'd1, 16'h1234, 1'b0, 1'b0, 16'h0);
    idle(3);  // R5 idle after read
    // demultiplexed write via window 1 (wins over window 2)
    doReq(4'd2, 16'h4321, 1'b1, 1'b0, 16'h5A5A);
    idle(3);  // R5 idle after write
    // R7: internal access with a covering window leaves pins alone
    doReq(4'd1, 16'h0042, 1'b0, 1'b1, 16'h0);
    idle(2);
    // R6: no matching active window
    doReq(4'd3, 16'h0777, 1'b1, 1'b0, 16'hC3C3);
    idle(2);
    // R8: hold raised in the latch clock waits for the cycle end
    adIn = 16'h0F0F;
    setReq(4'd1, 16'h2468, 1'b0, 1'b0, 16'h0);
    @(posedge clk); #2;
    holdReq = 1'b1;
    waitDone();
    idle(3);
    // R9 R11: internal served during hold, external stalls
    doReq(4'd2, 16'h0101, 1'b0, 1'b1, 16'h0);
    setReq(4'd2, 16'h3030, 1'b1, 1'b0, 16'h9999);
    idle(4);
    // R10: release, then the stalled request runs
    holdReq = 1'b0;
    waitDone();
    idle(2);
    // R8: hold and external request in the same idle clock
    setReq(4'd1, 16'h5555, 1'b0, 1'b0, 16'h0);
    holdReq = 1'b1;
    idle(3);
    holdReq = 1'b0;
    waitDone();
    idle(2);
    // R4: no demultiplexed window releases the address port
    winDemux = 4'b0000;
    idle(2);
    doReq(4'd2, 16'hABCD, 1'b1, 1'b0, 16'h1357);
    idle(3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule